// File: doc/BRIEF.md
# Power-of-two segment address translator

The translator turns a 24-bit logical address into a physical address using a table of 32 segment descriptors. Each segment covers a naturally aligned region of 2^k bytes. A descriptor stores a logical base, a size mask with contiguous ones at the top, a physical base, a 4-bit address-space tag and three protection bits. Bits that the mask clears pass through untranslated. Bits that the mask sets come from the physical base.

Lookups are fully pipelined and accept one request per cycle. Each response appears exactly two cycles after its request, which models two wait states. A response is a hit with the translated address, a miss, or a protection fault. The lowest-numbered matching entry decides the outcome.

A load port writes or invalidates one descriptor per cycle by index. A descriptor whose bases are not aligned to its own mask is refused, and the table is left unchanged.

Top module: `seg_xlate`

## Requirements
- R1: An entry matches when it is valid, its tag equals `req_asid_i`, and `(req_addr_i & mask) == logical_base`. On a hit, `rsp_paddr_o = (phys_base & mask) | (req_addr_i & ~mask)`.
- R2: A request sampled at one clock edge produces `rsp_valid_o` high after the second edge that follows, with exactly one of `rsp_hit_o`, `rsp_miss_o` or `rsp_fault_o` set. Back-to-back requests give back-to-back responses. While `rsp_valid_o` is low, all flags, `rsp_paddr_o` and `rsp_idx_o` are zero.
- R3: When no valid entry matches, the response is a miss with `rsp_paddr_o` = 0 and `rsp_idx_o` = 0.
- R4: When several entries match, the lowest-numbered one decides the result, and `rsp_idx_o` reports its index.
- R5: An entry whose tag differs from `req_asid_i` never matches, even when its address range covers the request.
- R6: Protection bits are `ld_prot_i[0]` = read allowed, `[1]` = write allowed, `[2]` = supervisor only. The winning entry produces a fault when any of these holds:
  - a read is made without read permission;
  - a write is made without write permission;
  - a user access (`req_user_i` = 1) reaches a supervisor-only entry.
  On a fault, `rsp_paddr_o` = 0 and `rsp_idx_o` holds the entry index.
- R7: A load with `ld_valid_i` writes entry `ld_idx_i`. If `ld_clear_i` is also set, the load only clears that entry's valid bit. A request presented in the same cycle as a load sees the old contents. A request presented in the next cycle sees the new contents.
- R8: A load that is not a clear is rejected when any of these holds:
  - the inverted mask is not of the form 2^k-1;
  - the logical base has a bit set below the mask;
  - the physical base has a bit set below the mask.
  A rejected load leaves the entry unchanged, and `ld_err_o` is high for exactly the cycle after it.
- R9: After reset every entry is invalid and all outputs are zero.
- R10: All 32 indices, 0 to 31, can be loaded. Mask all-ones (one-byte segment) and mask zero (whole address space) are both legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 24 | Logical address |
| req_asid_i | input | 4 | Current address-space tag |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_user_i | input | 1 | 1 = user mode, 0 = supervisor |
| ld_valid_i | input | 1 | Descriptor load strobe |
| ld_clear_i | input | 1 | Invalidate the indexed entry instead of writing it |
| ld_idx_i | input | 5 | Entry index |
| ld_lbase_i | input | 24 | Logical base |
| ld_mask_i | input | 24 | Size mask |
| ld_pbase_i | input | 24 | Physical base |
| ld_asid_i | input | 4 | Address-space tag |
| ld_prot_i | input | 3 | {supervisor only, write allowed, read allowed} |
| ld_err_o | output | 1 | Previous load was rejected |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_hit_o | output | 1 | Translation succeeded |
| rsp_miss_o | output | 1 | No matching entry |
| rsp_fault_o | output | 1 | Protection violation |
| rsp_paddr_o | output | 24 | Physical address on a hit, else 0 |
| rsp_idx_o | output | 5 | Winning entry on a hit or fault, else 0 |

## Verification
The bench overlaps segments of different sizes so that a priority encoder that favoured the highest index would return the wrong physical base. It clears the low entry and checks that the next one takes over. It issues a lookup in the same cycle as a load and again in the next cycle; a table read after the write edge would turn the expected miss into a hit there. It sends misaligned and non-contiguous masks, including one over a live entry, and a design that wrote them anyway would change later translations. It also covers read-only, write-only and supervisor-only segments, tag mismatches, and the one-byte and whole-space extremes at entries 30 and 31.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int PROT_W   = 3;
  localparam int PROT_RD  = 0;
  localparam int PROT_WR  = 1;
  localparam int PROT_SUP = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int N_ENT  = 32,
  parameter int ADDR_W = 24,
  parameter int TAG_W  = 4,
  parameter int PROT_W = seg_xlate_pkg::PROT_W,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic              ld_clear_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ADDR_W-1:0] ld_lbase_i,
  input  logic [ADDR_W-1:0] ld_mask_i,
  input  logic [ADDR_W-1:0] ld_pbase_i,
  input  logic [TAG_W-1:0]  ld_asid_i,
  input  logic [PROT_W-1:0] ld_prot_i,
  output logic              ld_err_o,
  output logic              vld_o   [N_ENT],
  output logic [ADDR_W-1:0] lbase_o [N_ENT],
  output logic [ADDR_W-1:0] mask_o  [N_ENT],
  output logic [ADDR_W-1:0] pbase_o [N_ENT],
  output logic [TAG_W-1:0]  asid_o  [N_ENT],
  output logic [PROT_W-1:0] prot_o  [N_ENT]
);
  logic [ADDR_W-1:0] inv_mask;
  logic              shape_ok, ld_ok, wr_en;

  // offset field must be 2^k-1 and both bases clear inside it
  assign inv_mask = ~ld_mask_i;
  assign shape_ok = ((inv_mask & (inv_mask + ADDR_W'(1))) == '0);
  assign ld_ok    = shape_ok && ((ld_lbase_i & inv_mask) == '0)
                             && ((ld_pbase_i & inv_mask) == '0);
  assign wr_en    = ld_valid_i && !ld_clear_i && ld_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ld_err_o <= 1'b0;
    else         ld_err_o <= ld_valid_i && !ld_clear_i && !ld_ok;
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic sel;
    assign sel = (ld_idx_i == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[i]   <= 1'b0;
        lbase_o[i] <= '0;
        mask_o[i]  <= '0;
        pbase_o[i] <= '0;
        asid_o[i]  <= '0;
        prot_o[i]  <= '0;
      end else if (sel && ld_valid_i && ld_clear_i) begin
        vld_o[i] <= 1'b0;
      end else if (sel && wr_en) begin
        vld_o[i]   <= 1'b1;
        lbase_o[i] <= ld_lbase_i;
        mask_o[i]  <= ld_mask_i;
        pbase_o[i] <= ld_pbase_i;
        asid_o[i]  <= ld_asid_i;
        prot_o[i]  <= ld_prot_i;
      end
    end
  end
endmodule

// File: rtl/seg_match.sv
module seg_match #(
  parameter int N_ENT  = 32,
  parameter int ADDR_W = 24,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              vld_i   [N_ENT],
  input  logic [ADDR_W-1:0] lbase_i [N_ENT],
  input  logic [ADDR_W-1:0] mask_i  [N_ENT],
  input  logic [TAG_W-1:0]  asid_i  [N_ENT],
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  cur_asid_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [N_ENT-1:0] hit_vec;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit_vec[i] = vld_i[i] && (asid_i[i] == cur_asid_i)
                        && ((addr_i & mask_i[i]) == lbase_i[i]);
  end

  assign hit_o = |hit_vec;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int N_ENT  = 32,
  parameter int ADDR_W = 24,
  parameter int TAG_W  = 4,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int PROT_W = seg_xlate_pkg::PROT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TAG_W-1:0]  req_asid_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  input  logic              ld_valid_i,
  input  logic              ld_clear_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ADDR_W-1:0] ld_lbase_i,
  input  logic [ADDR_W-1:0] ld_mask_i,
  input  logic [ADDR_W-1:0] ld_pbase_i,
  input  logic [TAG_W-1:0]  ld_asid_i,
  input  logic [PROT_W-1:0] ld_prot_i,
  output logic              ld_err_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_fault_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [IDX_W-1:0]  rsp_idx_o
);
  import seg_xlate_pkg::*;

  logic              t_vld   [N_ENT];
  logic [ADDR_W-1:0] t_lbase [N_ENT];
  logic [ADDR_W-1:0] t_mask  [N_ENT];
  logic [ADDR_W-1:0] t_pbase [N_ENT];
  logic [TAG_W-1:0]  t_asid  [N_ENT];
  logic [PROT_W-1:0] t_prot  [N_ENT];

  logic              m_hit;
  logic [IDX_W-1:0]  m_idx;

  seg_table #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .PROT_W(PROT_W)) u_table (
    .clk_i, .rst_ni,
    .ld_valid_i, .ld_clear_i, .ld_idx_i, .ld_lbase_i, .ld_mask_i,
    .ld_pbase_i, .ld_asid_i, .ld_prot_i, .ld_err_o,
    .vld_o(t_vld), .lbase_o(t_lbase), .mask_o(t_mask),
    .pbase_o(t_pbase), .asid_o(t_asid), .prot_o(t_prot)
  );

  seg_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_match (
    .vld_i(t_vld), .lbase_i(t_lbase), .mask_i(t_mask), .asid_i(t_asid),
    .addr_i(req_addr_i), .cur_asid_i(req_asid_i),
    .hit_o(m_hit), .idx_o(m_idx)
  );

  // stage 1: match result and winning descriptor fields
  logic              s1_valid, s1_hit, s1_wr, s1_user;
  logic [ADDR_W-1:0] s1_addr, s1_mask, s1_pbase;
  logic [PROT_W-1:0] s1_prot;
  logic [IDX_W-1:0]  s1_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_wr    <= 1'b0;
      s1_user  <= 1'b0;
      s1_addr  <= '0;
      s1_mask  <= '0;
      s1_pbase <= '0;
      s1_prot  <= '0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= req_valid_i;
      s1_hit   <= req_valid_i && m_hit;
      s1_wr    <= req_write_i;
      s1_user  <= req_user_i;
      s1_addr  <= req_addr_i;
      s1_mask  <= t_mask[m_idx];
      s1_pbase <= t_pbase[m_idx];
      s1_prot  <= t_prot[m_idx];
      s1_idx   <= m_idx;
    end
  end

  // stage 2: protection and address formation
  logic s1_fault, s1_ok;
  assign s1_fault = s1_hit && ((s1_wr && !s1_prot[PROT_WR]) ||
                               (!s1_wr && !s1_prot[PROT_RD]) ||
                               (s1_user && s1_prot[PROT_SUP]));
  assign s1_ok    = s1_valid && s1_hit && !s1_fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_idx_o   <= '0;
    end else begin
      rsp_valid_o <= s1_valid;
      rsp_hit_o   <= s1_ok;
      rsp_miss_o  <= s1_valid && !s1_hit;
      rsp_fault_o <= s1_valid && s1_fault;
      rsp_paddr_o <= s1_ok ? ((s1_pbase & s1_mask) | (s1_addr & ~s1_mask)) : '0;
      rsp_idx_o   <= (s1_valid && s1_hit) ? s1_idx : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              ld_valid_i,
  input logic              ld_clear_i,
  input logic              ld_err_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_miss_o,
  input logic              rsp_fault_o,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic [IDX_W-1:0]  rsp_idx_o
);
  logic [1:0] seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen <= '0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end

  p_one_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_hit_o && !rsp_miss_o && !rsp_fault_o &&
                      rsp_paddr_o == '0 && rsp_idx_o == '0));

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd2) |-> (rsp_valid_o == $past(req_valid_i, 2)));

  p_miss_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_paddr_o == '0 && rsp_idx_o == '0));

  p_fault_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_paddr_o == '0);

  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && ld_err_o) |-> $past(ld_valid_i && !ld_clear_i));
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .ld_valid_i(ld_valid_i), .ld_clear_i(ld_clear_i), .ld_err_o(ld_err_o),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_miss_o(rsp_miss_o),
  .rsp_fault_o(rsp_fault_o), .rsp_paddr_o(rsp_paddr_o), .rsp_idx_o(rsp_idx_o)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_asid = '0;
  logic        ld_valid = 0, ld_clear = 0;
  logic [4:0]  ld_idx = '0;
  logic [23:0] ld_lbase = '0, ld_mask = '0, ld_pbase = '0;
  logic [3:0]  ld_asid = '0;
  logic [2:0]  ld_prot = '0;
  logic        ld_err, rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [23:0] rsp_paddr;
  logic [4:0]  rsp_idx;

  seg_xlate dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_asid_i(req_asid),
    .req_write_i(req_write), .req_user_i(req_user),
    .ld_valid_i(ld_valid), .ld_clear_i(ld_clear), .ld_idx_i(ld_idx),
    .ld_lbase_i(ld_lbase), .ld_mask_i(ld_mask), .ld_pbase_i(ld_pbase),
    .ld_asid_i(ld_asid), .ld_prot_i(ld_prot), .ld_err_o(ld_err),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr), .rsp_idx_o(rsp_idx)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic        hit, miss, fault;
    logic [23:0] pa;
    logic [4:0]  idx;
    int          due;
  } exp_t;
  exp_t  sb[$];
  string sb_tag[$];

  // reference table
  logic        m_vld [32];
  logic [23:0] m_lb [32], m_mk [32], m_pb [32];
  logic [3:0]  m_as [32];
  logic [2:0]  m_pr [32];

  logic        pend_ld = 0, pend_err = 0;
  string       pend_tag;

  function automatic logic load_ok(logic [23:0] lb, logic [23:0] mk, logic [23:0] pb);
    logic [23:0] low;
    low = ~mk;
    return ((low & (low + 24'd1)) == 24'd0) && ((lb & low) == 0) && ((pb & low) == 0);
  endfunction

  function automatic exp_t predict(logic [23:0] a, logic [3:0] as, logic wr, logic us);
    exp_t e;
    e.hit = 0; e.miss = 1; e.fault = 0; e.pa = 0; e.idx = 0; e.due = 0;
    for (int i = 0; i < 32; i++) begin
      if (e.miss && m_vld[i] && m_as[i] == as && (a & m_mk[i]) == m_lb[i]) begin
        e.miss = 0;
        e.idx  = 5'(i);
        if ((wr && !m_pr[i][1]) || (!wr && !m_pr[i][0]) || (us && m_pr[i][2])) begin
          e.fault = 1;
        end else begin
          e.hit = 1;
          e.pa  = (m_pb[i] & m_mk[i]) | (a & ~m_mk[i]);
        end
      end
    end
    return e;
  endfunction

  task automatic set_load(input logic [4:0] i, input logic clr, input logic [23:0] lb,
                          input logic [23:0] mk, input logic [23:0] pb,
                          input logic [3:0] as, input logic [2:0] pr, input string tag);
    ld_valid = 1; ld_clear = clr; ld_idx = i; ld_lbase = lb; ld_mask = mk;
    ld_pbase = pb; ld_asid = as; ld_prot = pr;
    pend_ld  = 1; pend_tag = tag;
    pend_err = !clr && !load_ok(lb, mk, pb);
  endtask

  task automatic set_req(input logic [23:0] a, input logic [3:0] as, input logic wr,
                         input logic us, input string tag);
    exp_t e;
    e = predict(a, as, wr, us);
    e.due = cyc + 2;
    sb.push_back(e);
    sb_tag.push_back(tag);
    req_valid = 1; req_addr = a; req_asid = as; req_write = wr; req_user = us;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (pend_ld) begin
      checks++;
      if (ld_err !== pend_err) begin
        failures++;
        $display("FAIL %s ld_err act=%b exp=%b", pend_tag, ld_err, pend_err);
      end
      if (ld_clear) m_vld[ld_idx] = 0;
      else if (!pend_err) begin
        m_vld[ld_idx] = 1; m_lb[ld_idx] = ld_lbase; m_mk[ld_idx] = ld_mask;
        m_pb[ld_idx] = ld_pbase; m_as[ld_idx] = ld_asid; m_pr[ld_idx] = ld_prot;
      end
      pend_ld = 0;
    end
    ld_valid = 0; ld_clear = 0; req_valid = 0;
  endtask

  task automatic do_load(input logic [4:0] i, input logic clr, input logic [23:0] lb,
                         input logic [23:0] mk, input logic [23:0] pb,
                         input logic [3:0] as, input logic [2:0] pr, input string tag);
    set_load(i, clr, lb, mk, pb, as, pr, tag);
    tick();
  endtask

  task automatic do_req(input logic [23:0] a, input logic [3:0] as, input logic wr,
                        input logic us, input string tag);
    set_req(a, as, wr, us, tag);
    tick();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected response act=valid exp=idle");
      end else begin
        exp_t  e;
        string t;
        e = sb.pop_front();
        t = sb_tag.pop_front();
        if (rsp_hit !== e.hit || rsp_miss !== e.miss || rsp_fault !== e.fault ||
            rsp_paddr !== e.pa || rsp_idx !== e.idx || cyc != e.due) begin
          failures++;
          $display("FAIL %s act h/m/f=%b%b%b pa=%h idx=%0d cyc=%0d exp h/m/f=%b%b%b pa=%h idx=%0d cyc=%0d",
                   t, rsp_hit, rsp_miss, rsp_fault, rsp_paddr, rsp_idx, cyc,
                   e.hit, e.miss, e.fault, e.pa, e.idx, e.due);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || rsp_fault !== 0 ||
        rsp_paddr !== 0 || rsp_idx !== 0 || ld_err !== 0) begin
      failures++;
      $display("FAIL R9 reset outputs act=%b%b%b%b pa=%h exp=0000 pa=000000",
               rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr);
    end
    rst_n = 1;
    @(negedge clk);

    do_req(24'h000000, 4'd0, 0, 0, "R9 empty table miss");
    do_req(24'h123456, 4'd1, 0, 1, "R3 miss before load");

    // 1 MB segment
    do_load(5'd0, 0, 24'h100000, 24'hF00000, 24'h300000, 4'd1, 3'b011, "R7 load e0");
    do_req(24'h123456, 4'd1, 0, 1, "R1 1MB translate");
    do_req(24'h1FFFFF, 4'd1, 1, 0, "R1 top byte of segment");
    do_req(24'h123456, 4'd2, 0, 1, "R5 tag mismatch");

    // overlapping smaller segments
    do_load(5'd5, 0, 24'h123400, 24'hFFFF00, 24'hABCD00, 4'd1, 3'b011, "R7 load e5");
    do_load(5'd2, 0, 24'h123400, 24'hFFFF00, 24'h777700, 4'd1, 3'b011, "R7 load e2");
    do_req(24'h1234AB, 4'd1, 0, 0, "R4 lowest wins e0");
    do_load(5'd0, 1, 24'h0, 24'h0, 24'h0, 4'd0, 3'b000, "R7 clear e0");
    do_req(24'h1234AB, 4'd1, 0, 0, "R4 e2 over e5");
    do_req(24'h100010, 4'd1, 0, 0, "R7 cleared entry misses");

    // protection
    do_load(5'd7, 0, 24'h400000, 24'hFF0000, 24'h050000, 4'd1, 3'b001, "R7 load ro e7");
    do_req(24'h40ABCD, 4'd1, 1, 0, "R6 write to read-only");
    do_req(24'h40ABCD, 4'd1, 0, 1, "R6 read of read-only");
    do_load(5'd8, 0, 24'h500000, 24'hFF0000, 24'h060000, 4'd1, 3'b111, "R7 load sup e8");
    do_req(24'h500123, 4'd1, 0, 1, "R6 user on supervisor-only");
    do_req(24'h500123, 4'd1, 1, 0, "R6 supervisor write ok");
    do_load(5'd9, 0, 24'h510000, 24'hFF0000, 24'h070000, 4'd1, 3'b010, "R7 load wo e9");
    do_req(24'h510001, 4'd1, 0, 0, "R6 read of write-only");
    do_req(24'h510001, 4'd1, 1, 1, "R6 user write of write-only");

    // rejected loads
    do_load(5'd10, 0, 24'h600010, 24'hFFFF00, 24'h000000, 4'd1, 3'b011, "R8 lbase misaligned");
    do_req(24'h600010, 4'd1, 0, 0, "R8 rejected entry absent");
    do_load(5'd10, 0, 24'h600000, 24'hFFFF00, 24'h000080, 4'd1, 3'b011, "R8 pbase misaligned");
    do_load(5'd10, 0, 24'h600000, 24'hF0F000, 24'h000000, 4'd1, 3'b011, "R8 non-contiguous mask");
    do_req(24'h600000, 4'd1, 0, 0, "R8 still absent");
    do_load(5'd7, 0, 24'h400001, 24'hFF0000, 24'h000000, 4'd1, 3'b011, "R8 bad overwrite e7");
    do_req(24'h40ABCD, 4'd1, 0, 0, "R8 e7 unchanged");

    // same-cycle visibility
    set_load(5'd11, 0, 24'h700000, 24'hFF0000, 24'h880000, 4'd2, 3'b011, "R7 load e11");
    set_req(24'h700001, 4'd2, 0, 0, "R7 same-cycle sees old");
    tick();
    do_req(24'h700001, 4'd2, 0, 0, "R7 next cycle sees new");
    set_load(5'd11, 1, 24'h0, 24'h0, 24'h0, 4'd0, 3'b000, "R7 clear e11");
    set_req(24'h700002, 4'd2, 0, 0, "R7 same-cycle clear sees old");
    tick();
    do_req(24'h700002, 4'd2, 0, 0, "R7 after clear miss");

    // size extremes and last index
    do_load(5'd31, 0, 24'h800000, 24'hFFFFFF, 24'h012345, 4'd15, 3'b011, "R10 load e31");
    do_req(24'h800000, 4'd15, 0, 0, "R10 one-byte segment hit");
    do_req(24'h800001, 4'd15, 0, 0, "R10 one-byte neighbour miss");
    do_load(5'd30, 0, 24'h000000, 24'h000000, 24'h000000, 4'd3, 3'b011, "R10 load whole-space e30");
    do_req(24'hFEDCBA, 4'd3, 1, 1, "R10 whole-space identity");

    // back-to-back stream
    for (int k = 0; k < 6; k++) begin
      do_req(24'h400000 + 24'(k * 24'h011111), 4'd1, k[0], k[1], "R2 back-to-back");
    end

    repeat (4) tick();
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R2 missing responses act=%0d exp=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule